// File: doc/BRIEF.md
# Reset, Watchdog and Low-Power Mode Controller

This block produces the internal reset of a small microcontroller and sequences its low-power states. The external reset pin is sampled on every oscillator clock; an internal reset is issued only once the pin has been seen high for a full qualification window, and it is released on the first clock that sees the pin low. A watchdog built from a clock prescaler and an 8-bit up-counter runs while the watchdog enable pin is high. When it wraps past its top value it drives the reset pin high for a fixed number of clocks, so the pin loop resets the whole device. Software reloads the watchdog with a two-write handshake: an arm write followed by a load write.

A four-state machine (PS_RESET, PS_RUN, PS_IDLE, PS_PDOWN) owns the clock-gating enables and the pin overrides. The transitions are:
- `rst_to_run`: PS_RESET goes to PS_RUN once the internal reset is gone.
- `run_to_idle`: a mode write requesting idle.
- `run_to_pdown`: a mode write requesting power-down while the watchdog enable is low. Power-down wins if both bits are set.
- `idle_to_run`: any wake request.
- `any_to_reset`: the internal reset, from every state.

PS_PDOWN has no other exit. The watchdog pulse itself runs in a two-state machine, WD_COUNT and WD_PULSE.

The block is clocked by the oscillator clock and has an asynchronous power-on input. It reports the mode through these outputs:
- clock enables for the CPU and for the peripherals;
- an oscillator-run flag;
- pin-override controls for the address-latch and program-strobe level, the PWM pins, and the low address/data port.

Top module: `rstpwr_ctrl`

## Requirements
- R1: `sys_rst` rises only after `rst_pin_in` has been sampled high on RST_MIN (24) consecutive rising clock edges; a high pulse of 23 edges has no effect.
- R2: `sys_rst` falls on the first edge that samples `rst_pin_in` low. While the state is PS_RESET, `cpu_clk_en`=0, `per_clk_en`=0 and `osc_run`=1. PS_RUN follows one edge after `sys_rst` falls and sets all three to 1.
- R3: With `wdt_en_pin`=1 the watchdog counter advances once every WDT_PRESC (12) clocks. The tick taken while the counter is 255 drives `rst_pin_drive` high for exactly PULSE_LEN (24) clocks. After a reload to value v, the pulse starts (256-v)*12 enabled clocks later.
- R4: The watchdog pulse, looped back to `rst_pin_in`, produces `sys_rst`.
- R5: A load write (`wdt_wr`=1, `wdt_wr_sel`=1) reloads the counter from `wdt_wr_data` and clears the prescaler only if an arm write (`wdt_wr`=1, `wdt_wr_sel`=0) came before it. Every load write clears the arm, so an unarmed or second load is ignored.
- R6: With `wdt_en_pin`=0 the watchdog does not count and `rst_pin_drive` stays 0.
- R7: In PS_IDLE, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_run`=1.
- R8: PS_IDLE returns to PS_RUN on the edge that samples `wake_irq`=1. `sys_rst` also ends idle, through PS_RESET.
- R9: In PS_PDOWN, `osc_run`=0, `cpu_clk_en`=0 and `per_clk_en`=0. `wake_irq` is ignored, and only `sys_rst` leaves the state.
- R10: A power-down request is ignored while `wdt_en_pin`=1; if idle is requested in the same write, idle is entered instead.
- R11: In both low-power states `pin_override`=1 and `pwm_force_hi`=1. `ale_psen_lvl` is 1 in idle and 0 in power-down. `p0_float` equals `ext_prog`; in PS_RUN and PS_RESET all four outputs are 0.
- R12: `por_n`=0 asynchronously sets `sys_rst`=1, places the state machine in PS_RESET and clears the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_in | input | 1 | Sampled level of the reset pin |
| wdt_en_pin | input | 1 | Watchdog enable pin; also blocks power-down |
| mode_wr | input | 1 | Mode register write strobe |
| mode_idle | input | 1 | Idle request bit of the mode write |
| mode_pdown | input | 1 | Power-down request bit of the mode write |
| wake_irq | input | 1 | An enabled interrupt is pending |
| ext_prog | input | 1 | Code is executing from external program memory |
| wdt_wr | input | 1 | Watchdog write strobe |
| wdt_wr_sel | input | 1 | 0 = arm write, 1 = load write |
| wdt_wr_data | input | WDT_W | Reload value for a load write |
| sys_rst | output | 1 | Internal reset |
| rst_pin_drive | output | 1 | Drives the reset pin high during a watchdog pulse |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| pin_override | output | 1 | Bus and PWM pins are under low-power control |
| ale_psen_lvl | output | 1 | Level forced on the address-latch and program-strobe pins |
| pwm_force_hi | output | 1 | Forces both PWM pins high |
| p0_float | output | 1 | Low address/data port floats instead of holding data |

## Verification
The bench attacks the reset filter at its boundary. A 23-edge high pulse must be ignored and a 24-edge pulse must be taken; a filter off by one would reset on the short pulse or miss the long one. The watchdog is reloaded near its top so that its overflow cycle and its pulse length are counted exactly. A wrong prescaler, a pulse of the wrong length, or a pulse that fails to loop into `sys_rst` would show up as a count mismatch. The reload handshake is probed with an unarmed load and with a second load after a single arm; a design that accepts either would fire at the wrong time. Power-down is requested with the watchdog enabled, to catch a design that enters a state the watchdog cannot leave. In power-down, `wake_irq` is pulsed to catch a state that exits the way idle does.

// File: rtl/rstpwr_pkg.sv
package rstpwr_pkg;

    // Low-power sequencing states
    typedef enum logic [1:0] {
        PS_RESET = 2'd0,
        PS_RUN   = 2'd1,
        PS_IDLE  = 2'd2,
        PS_PDOWN = 2'd3
    } pwr_state_t;

    // Watchdog pulse states
    typedef enum logic {
        WD_COUNT = 1'b0,
        WD_PULSE = 1'b1
    } wdt_state_t;

    // Watchdog write selector encoding
    localparam logic WSEL_ARM  = 1'b0;
    localparam logic WSEL_LOAD = 1'b1;

endpackage

// File: rtl/rstpwr_filter.sv
module rstpwr_filter #(
    parameter int RST_MIN = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_in,
    output logic sys_rst
);
    localparam int CW = $clog2(RST_MIN + 1);

    logic [CW-1:0] hi_cnt;

    // Count consecutive high samples; reset qualifies on the RST_MIN-th
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_cnt  <= '0;
            sys_rst <= 1'b1;
        end else if (!pin_in) begin
            hi_cnt  <= '0;
            sys_rst <= 1'b0;
        end else begin
            if (hi_cnt != CW'(RST_MIN))
                hi_cnt <= hi_cnt + 1'b1;
            if (hi_cnt == CW'(RST_MIN - 1))
                sys_rst <= 1'b1;
        end
    end
endmodule

// File: rtl/rstpwr_wdt.sv
module rstpwr_wdt
    import rstpwr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PRESC     = 12,
    parameter int PULSE_LEN = 24
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst,
    input  logic             enable,
    input  logic             wr,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pulse_out
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam int LW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    wdt_state_t        wd_state, wd_next;
    logic [PW-1:0]     presc;
    logic [CNT_W-1:0]  cnt;
    logic [LW-1:0]     plen;
    logic              armed;
    logic              run, tick, ovf, load_ok;

    assign run     = enable && !sys_rst && (wd_state == WD_COUNT);
    assign tick    = run && (presc == PW'(PRESC - 1));
    assign ovf     = tick && (cnt == '1);
    assign load_ok = wr && (wr_sel == WSEL_LOAD) && armed;

    // Prescaler, counter and arm/load handshake
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            presc <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else if (sys_rst) begin
            presc <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (wr)
                armed <= (wr_sel == WSEL_ARM);
            if (load_ok) begin
                cnt   <= wr_data;
                presc <= '0;
            end else if (run) begin
                presc <= tick ? '0 : presc + 1'b1;
                if (tick)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    // Pulse state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wd_state <= WD_COUNT;
            plen     <= '0;
        end else begin
            wd_state <= wd_next;
            plen     <= (wd_state == WD_PULSE) ? plen + 1'b1 : '0;
        end
    end

    // Pulse next-state
    always_comb begin
        wd_next = wd_state;
        unique case (wd_state)
            WD_COUNT: if (ovf) wd_next = WD_PULSE;
            WD_PULSE: if (plen == LW'(PULSE_LEN - 1)) wd_next = WD_COUNT;
        endcase
    end

    assign pulse_out = (wd_state == WD_PULSE);
endmodule

// File: rtl/rstpwr_fsm.sv
module rstpwr_fsm
    import rstpwr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic mode_wr,
    input  logic mode_idle,
    input  logic mode_pdown,
    input  logic wdt_en,
    input  logic wake_irq,
    input  logic ext_prog,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_run,
    output logic pin_override,
    output logic ale_psen_lvl,
    output logic pwm_force_hi,
    output logic p0_float
);
    pwr_state_t state, next;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= PS_RESET;
        else        state <= next;
    end

    // Transitions
    always_comb begin
        next = state;
        unique case (state)
            PS_RESET: next = PS_RUN;                       // rst_to_run
            PS_RUN: begin
                if (mode_wr) begin
                    if (mode_pdown && !wdt_en) next = PS_PDOWN;  // run_to_pdown
                    else if (mode_idle)        next = PS_IDLE;   // run_to_idle
                end
            end
            PS_IDLE:  if (wake_irq) next = PS_RUN;         // idle_to_run
            PS_PDOWN: next = PS_PDOWN;
        endcase
        if (sys_rst) next = PS_RESET;                      // any_to_reset
    end

    // Outputs
    always_comb begin
        cpu_clk_en   = 1'b0;
        per_clk_en   = 1'b0;
        osc_run      = 1'b1;
        pin_override = 1'b0;
        ale_psen_lvl = 1'b0;
        pwm_force_hi = 1'b0;
        p0_float     = 1'b0;
        unique case (state)
            PS_RESET: ;
            PS_RUN: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
            end
            PS_IDLE: begin
                per_clk_en   = 1'b1;
                pin_override = 1'b1;
                ale_psen_lvl = 1'b1;
                pwm_force_hi = 1'b1;
                p0_float     = ext_prog;
            end
            PS_PDOWN: begin
                osc_run      = 1'b0;
                pin_override = 1'b1;
                pwm_force_hi = 1'b1;
                p0_float     = ext_prog;
            end
        endcase
    end
endmodule

// File: rtl/rstpwr_ctrl.sv
module rstpwr_ctrl #(
    parameter int RST_MIN   = 24,
    parameter int PULSE_LEN = 24,
    parameter int WDT_W     = 8,
    parameter int WDT_PRESC = 12
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_pin_in,
    input  logic             wdt_en_pin,
    input  logic             mode_wr,
    input  logic             mode_idle,
    input  logic             mode_pdown,
    input  logic             wake_irq,
    input  logic             ext_prog,
    input  logic             wdt_wr,
    input  logic             wdt_wr_sel,
    input  logic [WDT_W-1:0] wdt_wr_data,
    output logic             sys_rst,
    output logic             rst_pin_drive,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_run,
    output logic             pin_override,
    output logic             ale_psen_lvl,
    output logic             pwm_force_hi,
    output logic             p0_float
);
    rstpwr_filter #(.RST_MIN(RST_MIN)) u_filter (
        .clk     (clk),
        .por_n   (por_n),
        .pin_in  (rst_pin_in),
        .sys_rst (sys_rst)
    );

    rstpwr_wdt #(
        .CNT_W     (WDT_W),
        .PRESC     (WDT_PRESC),
        .PULSE_LEN (PULSE_LEN)
    ) u_wdt (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst   (sys_rst),
        .enable    (wdt_en_pin),
        .wr        (wdt_wr),
        .wr_sel    (wdt_wr_sel),
        .wr_data   (wdt_wr_data),
        .pulse_out (rst_pin_drive)
    );

    rstpwr_fsm u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst      (sys_rst),
        .mode_wr      (mode_wr),
        .mode_idle    (mode_idle),
        .mode_pdown   (mode_pdown),
        .wdt_en       (wdt_en_pin),
        .wake_irq     (wake_irq),
        .ext_prog     (ext_prog),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_run      (osc_run),
        .pin_override (pin_override),
        .ale_psen_lvl (ale_psen_lvl),
        .pwm_force_hi (pwm_force_hi),
        .p0_float     (p0_float)
    );
endmodule

// File: rtl/rstpwr_ctrl_sva.sv
module rstpwr_ctrl_sva #(
    parameter int RST_MIN   = 24,
    parameter int PULSE_LEN = 24
) (
    input logic clk,
    input logic por_n,
    input logic rst_pin_in,
    input logic wdt_en_pin,
    input logic wake_irq,
    input logic sys_rst,
    input logic rst_pin_drive,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_run,
    input logic ale_psen_lvl,
    input logic pwm_force_hi
);
    logic [15:0] hi_run;
    logic [15:0] drv_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_run  <= '0;
            drv_len <= '0;
        end else begin
            hi_run  <= !rst_pin_in ? '0 : (hi_run == 16'hFFFF ? hi_run : hi_run + 1'b1);
            drv_len <= rst_pin_drive ? drv_len + 1'b1 : '0;
        end
    end

    // R1: reset only after a full window of high samples
    assert_rst_window_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> (hi_run >= 16'(RST_MIN)));

    // R3: watchdog pulse has the exact length
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_pin_drive) |-> (drv_len == 16'(PULSE_LEN)));

    // R8: idle leaves on a wake request
    assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!por_n)
        (per_clk_en && !cpu_clk_en && wake_irq && !sys_rst) |=> cpu_clk_en);

    // R9: power-down has no exit except reset
    assert_pd_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!osc_run && !sys_rst) |=> !osc_run);

    // R10: oscillator never stops while the watchdog is enabled
    assert_pd_blocked_R10: assert property (@(posedge clk) disable iff (!por_n)
        (osc_run && wdt_en_pin) |=> osc_run);

    // R11: power-down pin levels
    assert_pd_pins_R11: assert property (@(posedge clk) disable iff (!por_n)
        !osc_run |-> (!ale_psen_lvl && pwm_force_hi));
endmodule

bind rstpwr_ctrl rstpwr_ctrl_sva #(
    .RST_MIN   (RST_MIN),
    .PULSE_LEN (PULSE_LEN)
) u_sva (
    .clk           (clk),
    .por_n         (por_n),
    .rst_pin_in    (rst_pin_in),
    .wdt_en_pin    (wdt_en_pin),
    .wake_irq      (wake_irq),
    .sys_rst       (sys_rst),
    .rst_pin_drive (rst_pin_drive),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .osc_run       (osc_run),
    .ale_psen_lvl  (ale_psen_lvl),
    .pwm_force_hi  (pwm_force_hi)
);

// File: tb/rstpwr_ctrl_tb.sv
`timescale 1ns/1ps
module rstpwr_ctrl_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       por_n = 1'b0, ext_rst = 1'b0, wdt_en_pin = 1'b0;
    logic       mode_wr = 1'b0, mode_idle = 1'b0, mode_pdown = 1'b0;
    logic       wake_irq = 1'b0, ext_prog = 1'b0;
    logic       wdt_wr = 1'b0, wdt_wr_sel = 1'b0;
    logic [7:0] wdt_wr_data = 8'h00;
    logic       rst_pin_in;
    logic       sys_rst, rst_pin_drive, cpu_clk_en, per_clk_en, osc_run;
    logic       pin_override, ale_psen_lvl, pwm_force_hi, p0_float;

    assign rst_pin_in = ext_rst | rst_pin_drive;

    rstpwr_ctrl u_dut (
        .clk(clk), .por_n(por_n), .rst_pin_in(rst_pin_in), .wdt_en_pin(wdt_en_pin),
        .mode_wr(mode_wr), .mode_idle(mode_idle), .mode_pdown(mode_pdown),
        .wake_irq(wake_irq), .ext_prog(ext_prog), .wdt_wr(wdt_wr),
        .wdt_wr_sel(wdt_wr_sel), .wdt_wr_data(wdt_wr_data), .sys_rst(sys_rst),
        .rst_pin_drive(rst_pin_drive), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_run(osc_run), .pin_override(pin_override), .ale_psen_lvl(ale_psen_lvl),
        .pwm_force_hi(pwm_force_hi), .p0_float(p0_float)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 10 && !cpu_clk_en; i++) step(1);
    endtask

    task automatic mode_write(input logic idle, input logic pd);
        mode_wr = 1'b1; mode_idle = idle; mode_pdown = pd;
        step(1);
        mode_wr = 1'b0; mode_idle = 1'b0; mode_pdown = 1'b0;
    endtask

    task automatic wdt_write(input logic sel, input logic [7:0] data);
        wdt_wr = 1'b1; wdt_wr_sel = sel; wdt_wr_data = data;
        step(1);
        wdt_wr = 1'b0;
    endtask

    // Enables the watchdog and measures cycles to pulse, pulse length, reset
    task automatic fire_and_measure(input string tag, input int exp_delay);
        int n = 0, h = 0;
        wdt_en_pin = 1'b1;
        for (int i = 0; i < 400; i++) begin
            step(1); n++;
            if (rst_pin_drive) break;
        end
        check({tag, " overflow delay"}, n, exp_delay);
        h = 1;
        for (int i = 0; i < 100 && rst_pin_drive; i++) begin
            step(1);
            if (rst_pin_drive) h++;
        end
        check("R3 pulse length", h, 24);
        check("R4 pulse yields internal reset", sys_rst, 1);
        wdt_en_pin = 1'b0;
        wait_run();
    endtask

    task automatic t_reset();
        por_n = 1'b0;
        step(2);
        check("R12 por sets sys_rst", sys_rst, 1);
        check("R2 reset cpu_clk_en", cpu_clk_en, 0);
        check("R2 reset per_clk_en", per_clk_en, 0);
        check("R2 reset osc_run", osc_run, 1);
        check("R11 reset pin_override", pin_override, 0);
        por_n = 1'b1;
        step(1);
        check("R2 release on low pin", sys_rst, 0);
        step(1);
        check("R2 run cpu_clk_en", cpu_clk_en, 1);
        check("R2 run per_clk_en", per_clk_en, 1);
    endtask

    task automatic t_filter();
        int early = 0;
        ext_rst = 1'b1;
        for (int i = 0; i < 23; i++) begin step(1); if (sys_rst) early++; end
        ext_rst = 1'b0;
        step(1);
        check("R1 23-edge pulse ignored", early + sys_rst, 0);
        check("R1 cpu still running", cpu_clk_en, 1);
        ext_rst = 1'b1;
        step(23);
        check("R1 not yet at 23", sys_rst, 0);
        step(1);
        check("R1 reset at 24", sys_rst, 1);
        step(1);
        check("R2 reset state cpu off", cpu_clk_en, 0);
        ext_rst = 1'b0;
        step(1);
        check("R2 release", sys_rst, 0);
        step(1);
        check("R2 back to run", cpu_clk_en, 1);
    endtask

    task automatic t_idle();
        ext_prog = 1'b1;
        mode_write(1'b1, 1'b0);
        check("R7 idle cpu_clk_en", cpu_clk_en, 0);
        check("R7 idle per_clk_en", per_clk_en, 1);
        check("R7 idle osc_run", osc_run, 1);
        check("R11 idle ale_psen_lvl", ale_psen_lvl, 1);
        check("R11 idle pwm_force_hi", pwm_force_hi, 1);
        check("R11 idle pin_override", pin_override, 1);
        check("R11 idle p0_float ext", p0_float, 1);
        ext_prog = 1'b0; #1;
        check("R11 idle p0 holds int", p0_float, 0);
        step(5);
        check("R8 idle holds without wake", cpu_clk_en, 0);
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
        check("R8 wake to run", cpu_clk_en, 1);
        check("R11 run no override", pwm_force_hi, 0);
        mode_write(1'b1, 1'b0);
        ext_rst = 1'b1; step(25);
        check("R8 reset leaves idle", per_clk_en, 0);
        ext_rst = 1'b0; wait_run();
        check("R8 run after reset", cpu_clk_en, 1);
    endtask

    task automatic t_pd_blocked();
        wdt_en_pin = 1'b1;
        mode_write(1'b0, 1'b1);
        check("R10 pd blocked osc", osc_run, 1);
        check("R10 pd blocked cpu", cpu_clk_en, 1);
        mode_write(1'b1, 1'b1);
        check("R10 falls back to idle", per_clk_en, 1);
        check("R10 idle osc_run", osc_run, 1);
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
        wdt_en_pin = 1'b0;
        check("R8 wake after blocked pd", cpu_clk_en, 1);
    endtask

    task automatic t_pd();
        ext_prog = 1'b1;
        mode_write(1'b1, 1'b1);
        check("R9 pd osc_run", osc_run, 0);
        check("R9 pd cpu_clk_en", cpu_clk_en, 0);
        check("R9 pd per_clk_en", per_clk_en, 0);
        check("R11 pd ale_psen_lvl", ale_psen_lvl, 0);
        check("R11 pd pwm_force_hi", pwm_force_hi, 1);
        check("R11 pd p0_float", p0_float, 1);
        wake_irq = 1'b1; step(5); wake_irq = 1'b0;
        check("R9 wake ignored in pd", osc_run, 0);
        ext_prog = 1'b0;
        ext_rst = 1'b1; step(24);
        check("R9 pd reset seen", sys_rst, 1);
        step(1);
        check("R9 reset restarts osc", osc_run, 1);
        ext_rst = 1'b0; wait_run();
        check("R9 run after pd reset", cpu_clk_en, 1);
    endtask

    task automatic t_wdt_fire();
        int highs = 0;
        wdt_write(1'b0, 8'h00);
        wdt_write(1'b1, 8'd250);
        for (int i = 0; i < 200; i++) begin step(1); if (rst_pin_drive) highs++; end
        check("R6 disabled watchdog silent", highs, 0);
        fire_and_measure("R3", 72);
    endtask

    task automatic t_wdt_seq();
        int highs = 0;
        wdt_write(1'b1, 8'd250);
        wdt_en_pin = 1'b1;
        for (int i = 0; i < 100; i++) begin step(1); if (rst_pin_drive) highs++; end
        wdt_en_pin = 1'b0;
        check("R5 unarmed load ignored", highs, 0);
        wdt_write(1'b0, 8'h00);
        wdt_write(1'b1, 8'd250);
        wdt_write(1'b1, 8'd254);
        fire_and_measure("R5 armed load once", 72);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog timeout actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1);
        t_reset();
        t_filter();
        t_idle();
        t_pd_blocked();
        t_pd();
        t_wdt_fire();
        t_wdt_seq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule